// File: doc/BRIEF.md
# CPU Interrupt Input Pin Conditioner

This block sits in front of one processor core. It takes a small vector of external control pins and turns them into internal pending-interrupt bits and direct core-control levels. Every pin passes through a two-flop synchronizer. A detector then holds the last accepted level of each pin and reacts only to a real change, so a pin that keeps its level causes no action.

Each defined pin has a fixed sensitivity. Timebase enable, external interrupt, system-management interrupt and soft reset are active-high levels. Checkstop and hard reset are active-low levels. Machine check reacts only to a falling edge. Pending bits drive a combined interrupt request line. Software clears pending bits through a write-one-to-clear input. Pin positions above the defined set have no effect, but their levels are still recorded and visible on `pin_level_o`.

Top module: `irq_pin_cond`

## Requirements
- R1: During and right after a synchronous reset, `pend_o`, `irq_o`, `tb_run_o`, `core_halt_o` and `core_reset_o` are 0 and `pin_level_o` equals the idle vector (default 8'h38: bits 3, 4 and 5 high).
- R2: A pin that holds its recorded level produces no action. A level-sensitive pending bit that has been cleared by software stays clear while its pin stays high.
- R3: Pin 0 (timebase enable, active high) sets `tb_run_o` when it changes to 1 and clears it when it changes to 0.
- R4: Pin 1 (external interrupt) and pin 2 (system-management interrupt) are active-high levels. Each change copies the new level into pending bit 0 and pending bit 1 respectively.
- R5: A 1-to-0 change on pin 3 (machine check) sets pending bit 2. A rise on pin 3 never clears that bit; only the clear input or reset does.
- R6: A 1-to-0 change on pin 4 (checkstop, active low) sets `core_halt_o`. Only reset clears it; the pin returning high does not.
- R7: Pin 5 (hard reset, active low) drives `core_reset_o` to 1 while its recorded level is low and to 0 once it is high.
- R8: Pin 6 (soft reset, active high) copies each new level into pending bit 3.
- R9: Pins at index 7 and above change no output other than their own bit of `pin_level_o`, which follows the synchronized pin.
- R10: `irq_o` is 1 in every cycle in which any pending bit is 1, and 0 only when all pending bits are 0.
- R11: A 1 on `pend_clr_i[k]` clears pending bit k at the next edge, unless a pin event sets that bit at the same edge; in that case the set wins.
- R12: A pin change reaches the outputs on the third rising clock edge after it is applied: two synchronizer stages, then the detector and output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_PINS | Asynchronous control pins (indices in R3 to R9) |
| pend_clr_i | input | 4 | Write-one-to-clear strobes, one per pending bit |
| pend_o | output | 4 | Pending vector: bit 0 external, 1 system-management, 2 machine check, 3 soft reset |
| irq_o | output | 1 | Combined interrupt request |
| tb_run_o | output | 1 | Timebase runs when 1, frozen when 0 |
| core_halt_o | output | 1 | Core stopped by checkstop |
| core_reset_o | output | 1 | Hard reset request to the core |
| pin_level_o | output | N_PINS | Recorded synchronized level of every pin |

## Verification
The bench attacks three corner cases. The first is a software clear of a level bit while its pin stays high: a design that re-derives pending bits from pin levels instead of from changes would set the bit again at once. The second is a clear strobe that lands on the same edge as a pin set: wrong priority drops a real interrupt. The third is a rising machine-check or checkstop pin: an edge detector that also treats the rise as an event would wrongly clear the machine-check bit or restart the core. The bench also probes the exact three-edge latency and drives random traffic on the spare pin, where a decoder that failed to mask spare indices would create pending bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Pin positions; the decoder depends on these.
    localparam int PIN_TB      = 0;
    localparam int PIN_EXT     = 1;
    localparam int PIN_SMI     = 2;
    localparam int PIN_MCK_N   = 3;
    localparam int PIN_STOP_N  = 4;
    localparam int PIN_HRST_N  = 5;
    localparam int PIN_SRST    = 6;
    localparam int PIN_DEFINED = 7;

    // Pending vector positions.
    localparam int PND_EXT = 0;
    localparam int PND_SMI = 1;
    localparam int PND_MCK = 2;
    localparam int PND_RST = 3;
    localparam int PND_W   = 4;

    typedef enum logic [1:0] {
        SENSE_HIGH = 2'd0,
        SENSE_LOW  = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_NONE = 2'd3
    } sense_e;

    typedef struct packed {
        logic [PND_W-1:0] set;
        logic [PND_W-1:0] drop;
    } pend_evt_t;

    typedef struct packed {
        logic tb_on;
        logic tb_off;
        logic stop;
        logic hrst_on;
        logic hrst_off;
    } ctl_evt_t;

    function automatic sense_e sense_of(input int idx);
        case (idx)
            PIN_TB, PIN_EXT, PIN_SMI, PIN_SRST: return SENSE_HIGH;
            PIN_STOP_N, PIN_HRST_N:             return SENSE_LOW;
            PIN_MCK_N:                          return SENSE_FALL;
            default:                            return SENSE_NONE;
        endcase
    endfunction

    // Which pin feeds each pending bit.
    function automatic int pend_src(input int k);
        case (k)
            PND_EXT: return PIN_EXT;
            PND_SMI: return PIN_SMI;
            PND_MCK: return PIN_MCK_N;
            default: return PIN_SRST;
        endcase
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int              WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int                N_PINS = 8,
    parameter logic [N_PINS-1:0] IDLE   = 8'h38
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_PINS-1:0]      smp_i,
    output logic [N_PINS-1:0]      lvl_o,
    output logic [PIN_DEFINED-1:0] act_o,
    output logic [PIN_DEFINED-1:0] asrt_o
);
    logic [N_PINS-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= IDLE;
        else     lvl_q <= smp_i;
    end

    for (genvar i = 0; i < PIN_DEFINED; i++) begin : g_pin
        localparam sense_e SNS = sense_of(i);
        if (SNS == SENSE_FALL) begin : g_fall
            assign act_o[i]  = lvl_q[i] & ~smp_i[i];
            assign asrt_o[i] = ~smp_i[i];
        end else if (SNS == SENSE_LOW) begin : g_low
            assign act_o[i]  = lvl_q[i] ^ smp_i[i];
            assign asrt_o[i] = ~smp_i[i];
        end else begin : g_high
            assign act_o[i]  = lvl_q[i] ^ smp_i[i];
            assign asrt_o[i] = smp_i[i];
        end
    end

    assign lvl_o = lvl_q;

    // R2
    repeat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_i[PIN_DEFINED-1:0] == lvl_q[PIN_DEFINED-1:0]) |-> (act_o == '0));
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [PIN_DEFINED-1:0] act_i,
    input  logic [PIN_DEFINED-1:0] asrt_i,
    output pend_evt_t              pend_evt_o,
    output ctl_evt_t               ctl_evt_o
);
    logic [PND_W-1:0] set_v;
    logic [PND_W-1:0] drop_v;

    for (genvar k = 0; k < PND_W; k++) begin : g_pend
        localparam int SRC = pend_src(k);
        assign set_v[k] = act_i[SRC] & asrt_i[SRC];
        if (sense_of(SRC) == SENSE_FALL) begin : g_edge
            assign drop_v[k] = 1'b0;
        end else begin : g_level
            assign drop_v[k] = act_i[SRC] & ~asrt_i[SRC];
        end
    end

    assign pend_evt_o = '{set: set_v, drop: drop_v};

    assign ctl_evt_o = '{
        tb_on:    act_i[PIN_TB]     &  asrt_i[PIN_TB],
        tb_off:   act_i[PIN_TB]     & ~asrt_i[PIN_TB],
        stop:     act_i[PIN_STOP_N] &  asrt_i[PIN_STOP_N],
        hrst_on:  act_i[PIN_HRST_N] &  asrt_i[PIN_HRST_N],
        hrst_off: act_i[PIN_HRST_N] & ~asrt_i[PIN_HRST_N]
    };
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pend_evt_t        evt_i,
    input  logic [PND_W-1:0] clr_i,
    output logic [PND_W-1:0] pend_o,
    output logic             irq_o
);
    logic [PND_W-1:0] pend_q;
    logic [PND_W-1:0] pend_d;
    logic             irq_q;

    always_comb begin
        for (int k = 0; k < PND_W; k++) begin
            if (evt_i.set[k])       pend_d[k] = 1'b1;
            else if (evt_i.drop[k]) pend_d[k] = 1'b0;
            else if (clr_i[k])      pend_d[k] = 1'b0;
            else                    pend_d[k] = pend_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= |pend_d;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;

    // R11
    clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~evt_i.set) != '0) |=> ((pend_q & $past(clr_i & ~evt_i.set)) == '0));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.set != '0) |=> ((pend_q & $past(evt_i.set)) == $past(evt_i.set)));

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_q) |-> (pend_q == '0));
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
    import irqc_pkg::*;
#(
    parameter int                N_PINS     = 8,
    parameter logic [N_PINS-1:0] IDLE_LEVEL = 8'h38
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [3:0]        pend_clr_i,
    output logic [3:0]        pend_o,
    output logic              irq_o,
    output logic              tb_run_o,
    output logic              core_halt_o,
    output logic              core_reset_o,
    output logic [N_PINS-1:0] pin_level_o
);
    localparam int SPARE_W = N_PINS - PIN_DEFINED;

    logic [N_PINS-1:0]      smp;
    logic [N_PINS-1:0]      lvl;
    logic [PIN_DEFINED-1:0] act;
    logic [PIN_DEFINED-1:0] asrt;
    pend_evt_t              pend_evt;
    ctl_evt_t               ctl_evt;
    logic                   tb_q;
    logic                   halt_q;
    logic                   hrst_q;

    irqc_sync #(.WIDTH(N_PINS), .RST_VAL(IDLE_LEVEL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (smp)
    );

    irqc_detect #(.N_PINS(N_PINS), .IDLE(IDLE_LEVEL)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .smp_i  (smp),
        .lvl_o  (lvl),
        .act_o  (act),
        .asrt_o (asrt)
    );

    irqc_decode u_decode (
        .act_i      (act),
        .asrt_i     (asrt),
        .pend_evt_o (pend_evt),
        .ctl_evt_o  (ctl_evt)
    );

    irqc_pending u_pending (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (pend_evt),
        .clr_i  (pend_clr_i),
        .pend_o (pend_o),
        .irq_o  (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q   <= 1'b0;
            halt_q <= 1'b0;
            hrst_q <= 1'b0;
        end else begin
            if (ctl_evt.tb_on)         tb_q <= 1'b1;
            else if (ctl_evt.tb_off)   tb_q <= 1'b0;
            if (ctl_evt.stop)          halt_q <= 1'b1;
            if (ctl_evt.hrst_on)       hrst_q <= 1'b1;
            else if (ctl_evt.hrst_off) hrst_q <= 1'b0;
        end
    end

    assign tb_run_o     = tb_q;
    assign core_halt_o  = halt_q;
    assign core_reset_o = hrst_q;
    assign pin_level_o  = lvl;

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        core_halt_o |=> core_halt_o);

    // R5
    mck_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_o[PND_MCK] && !pend_clr_i[PND_MCK]) |=> pend_o[PND_MCK]);

    // R9
    spare_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((smp[PIN_DEFINED-1:0] == lvl[PIN_DEFINED-1:0]) && (pend_clr_i == '0))
        |=> ($stable(pend_o) && $stable(tb_run_o) && $stable(core_reset_o)));

    // R7
    hrst_follow_chk: assert property (@(posedge clk) disable iff (rst)
        core_reset_o |-> !pin_level_o[PIN_HRST_N]);

    if (SPARE_W > 0) begin : g_spare_note
        // Spare positions only feed pin_level_o through the detector register.
    end
endmodule

// File: tb/irq_pin_cond_bench.sv
`timescale 1ns/1ps
module irq_pin_cond_bench;
    localparam int         NP   = 8;
    localparam logic [7:0] IDLE = 8'h38;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pins = IDLE;
    logic [3:0] clr = 4'h0;
    logic [3:0] pend;
    logic       irq, tb_run, halt, creset;
    logic [7:0] plvl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_pin_cond u_irq_pin_cond (
        .clk (clk), .rst (rst), .pin_i (pins), .pend_clr_i (clr),
        .pend_o (pend), .irq_o (irq), .tb_run_o (tb_run),
        .core_halt_o (halt), .core_reset_o (creset), .pin_level_o (plvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: delay line of pin samples plus recorded state.
    logic [7:0] dq[$];
    logic [7:0] m_lvl, m_s2;
    logic [3:0] m_pend, m_next;
    logic       m_irq, m_tb, m_halt, m_hr;
    bit         m_ok = 0;

    always @(posedge clk) begin
        if (rst) begin
            dq.delete();
            dq.push_back(IDLE);
            dq.push_back(IDLE);
            m_lvl = IDLE; m_pend = 0; m_irq = 0; m_tb = 0; m_halt = 0; m_hr = 0;
            m_ok = 1;
        end else begin
            dq.push_back(pins);
            m_s2   = dq.pop_front();
            m_next = m_pend & ~clr;
            if (m_s2[0] != m_lvl[0]) m_tb = m_s2[0];
            if (m_s2[1] != m_lvl[1]) m_next[0] = m_s2[1];
            if (m_s2[2] != m_lvl[2]) m_next[1] = m_s2[2];
            if (m_lvl[3] && !m_s2[3]) m_next[2] = 1'b1;
            if (m_lvl[4] && !m_s2[4]) m_halt = 1'b1;
            if (m_s2[5] != m_lvl[5]) m_hr = !m_s2[5];
            if (m_s2[6] != m_lvl[6]) m_next[3] = m_s2[6];
            m_pend = m_next;
            m_irq  = |m_next;
            m_lvl  = m_s2;
        end
    end

    always @(negedge clk) begin
        if (m_ok && !done) begin
            chk("R3 tb_run", 32'(tb_run), 32'(m_tb));
            chk("R4 pend_ext", 32'(pend[0]), 32'(m_pend[0]));
            chk("R4 pend_smi", 32'(pend[1]), 32'(m_pend[1]));
            chk("R5 pend_mck", 32'(pend[2]), 32'(m_pend[2]));
            chk("R8 pend_rst", 32'(pend[3]), 32'(m_pend[3]));
            chk("R10 irq", 32'(irq), 32'(m_irq));
            chk("R6 halt", 32'(halt), 32'(m_halt));
            chk("R7 core_reset", 32'(creset), 32'(m_hr));
            chk("R9 pin_level", 32'(plvl), 32'(m_lvl));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; pins = IDLE; clr = 4'h0;
        cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        cyc(1);
        // R1 reset state
        chk("R1 pend", 32'(pend), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 tb_run", 32'(tb_run), 32'h0);
        chk("R1 halt", 32'(halt), 32'h0);
        chk("R1 core_reset", 32'(creset), 32'h0);
        chk("R1 pin_level", 32'(plvl), 32'(IDLE));

        // R12 latency: external pin high, visible on the third edge
        pins[1] = 1'b1;
        cyc(2);
        chk("R12 before third edge", 32'(pend[0]), 32'h0);
        cyc(1);
        chk("R12 at third edge", 32'(pend[0]), 32'h1);
        chk("R4 ext set", 32'(pend[0]), 32'h1);

        // R2 / R11: clear while pin stays high, no re-trigger
        cyc(2);
        clr = 4'b0001; cyc(1); clr = 4'h0;
        chk("R11 clear ext", 32'(pend[0]), 32'h0);
        cyc(5);
        chk("R2 held level no re-set", 32'(pend[0]), 32'h0);
        chk("R10 irq low when empty", 32'(irq), 32'h0);

        // R11: clear coinciding with set event; set wins
        pins[2] = 1'b1;
        cyc(2);
        clr = 4'b0010; cyc(1); clr = 4'h0;
        chk("R11 set wins over clear", 32'(pend[1]), 32'h1);
        pins[2] = 1'b0; cyc(4);
        chk("R4 smi drop", 32'(pend[1]), 32'h0);

        // R5: falling machine check sets; rise keeps
        pins[3] = 1'b0; cyc(4);
        chk("R5 mck set", 32'(pend[2]), 32'h1);
        pins[3] = 1'b1; cyc(4);
        chk("R5 mck kept after rise", 32'(pend[2]), 32'h1);
        chk("R10 irq with mck", 32'(irq), 32'h1);
        clr = 4'b0100; cyc(1); clr = 4'h0;
        chk("R5 mck cleared by strobe", 32'(pend[2]), 32'h0);

        // R3 timebase
        pins[0] = 1'b1; cyc(4);
        chk("R3 tb on", 32'(tb_run), 32'h1);
        pins[0] = 1'b0; cyc(4);
        chk("R3 tb off", 32'(tb_run), 32'h0);

        // R7 hard reset
        pins[5] = 1'b0; cyc(4);
        chk("R7 reset asserted", 32'(creset), 32'h1);
        pins[5] = 1'b1; cyc(4);
        chk("R7 reset released", 32'(creset), 32'h0);

        // R8 soft reset
        pins[6] = 1'b1; cyc(4);
        chk("R8 soft reset pending", 32'(pend[3]), 32'h1);
        pins[6] = 1'b0; cyc(4);
        chk("R8 soft reset dropped", 32'(pend[3]), 32'h0);

        // R9 spare pin
        clr = 4'hF; cyc(1); clr = 4'h0; cyc(1);
        pins[7] = 1'b1; cyc(4);
        chk("R9 spare recorded", 32'(plvl[7]), 32'h1);
        chk("R9 spare no pending", 32'(pend), 32'h0);
        pins[7] = 1'b0; cyc(4);
        chk("R9 spare no pending on fall", 32'(pend), 32'h0);

        // R6 checkstop
        pins[4] = 1'b0; cyc(4);
        chk("R6 halt set", 32'(halt), 32'h1);
        pins[4] = 1'b1; cyc(6);
        chk("R6 halt sticky", 32'(halt), 32'h1);
        do_reset(); cyc(1);
        chk("R6 halt cleared by reset", 32'(halt), 32'h0);

        // Random traffic against the reference model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (($urandom % 3) == 0) pins = 8'($urandom);
            clr = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
        end
        @(negedge clk); clr = 4'h0; pins = IDLE;
        cyc(6);
        clr = 4'hF; cyc(1); clr = 4'h0; cyc(1);
        chk("R10 irq low after full clear", 32'(irq), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule